// File: doc/BRIEF.md
# Programmable Event Counter Array

This block holds a bank of up-counters that a controller processor reads and programs as special registers. The lower part of the bank holds timers. An enabled timer advances on every clock cycle. When it reaches its programmed limit it reloads to zero and raises an interrupt, which makes it a periodic tick source. The upper part of the bank collects statistics. Each statistics counter watches one bit of a shared event bus, for example a strobe that marks a command pushed into a command queue. It advances in the cycles where that bit is high, raises an interrupt when it reaches its limit, and then keeps counting until it sticks at all-ones.

The processor reaches every counter through a single register port. An index selects the counter and a two-bit field code selects what is accessed: the count, the limit, the control word, or the pending flag. Writes take effect at the clock edge, and reads return data combinationally. Pending flags are sticky. The interrupt output always presents the lowest-numbered pending counter, and the processor retires that interrupt by writing one to its pending field.

The design holds no controller state machine. Each counter is a pair of processes: one register process and one next-state process. A combinational priority picker sits on top of the counters.

Top module: `evc_array`

## Requirements
- R1: After reset every count is 0, every limit is all-ones, every control word is 0, no pending flag is set and `irq_valid` is 0.
- R2: The field codes are: 0 for the count, 1 for the limit, 2 for the control word and 3 for the pending flag. In the control word, bit 0 is the enable and bits [SEL_W:1] are the event select; the other control bits read as 0. The pending flag reads on bit 0. `sr_rdata` follows `sr_idx` and `sr_field` combinationally.
- R3: A timer (index below NUM_TIMER) advances by one on every clock edge while it is enabled, and holds its value while it is disabled.
- R4: When a timer steps to a value equal to its limit, it loads 0 instead and sets its pending flag at the same edge.
- R5: A statistics counter advances by one only at edges where it is enabled and the event bus bit named by its select is 1. Other bits of the bus have no effect, and neither does a disabled counter.
- R6: A statistics counter saturates at all-ones. It never wraps, and holding at all-ones never sets its pending flag.
- R7: When a statistics counter steps to a value equal to its limit, it sets its pending flag and keeps counting.
- R8: A pending flag stays set until a write of 1 to bit 0 of field 3 for that counter. A write of 0 there leaves the flag unchanged.
- R9: `irq_valid` is 1 exactly when some flag is pending, and `irq_id` then names the lowest-numbered pending counter.
- R10: If a count write and an increment hit the same counter at the same edge, the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_bus | input | NUM_EVT | Event strobes watched by the statistics counters |
| sr_wr_en | input | 1 | Write strobe for the register port |
| sr_idx | input | $clog2(NUM_CNT) | Counter index for reads and writes |
| sr_field | input | 2 | Field code (count, limit, control, pending) |
| sr_wdata | input | CNT_W | Write data |
| sr_rdata | output | CNT_W | Read data for the addressed field |
| irq_valid | output | 1 | Some counter has a pending interrupt |
| irq_id | output | $clog2(NUM_CNT) | Lowest-numbered pending counter |

## Verification
The bench builds the array with 8 counters (4 timers and 4 statistics counters), an 8-bit count and a 4-bit event bus. The narrow count lets a statistics counter reach saturation, and the check that a pending flag does not fire spuriously at all-ones, within a few events. Short limits let timers wrap within a handful of cycles, so two of them can be pending together and the priority order of the interrupt can be observed. The small bus keeps the test of select bits against unselected bits exhaustive enough to show that only the chosen strobe counts.

// File: rtl/evc_pkg.sv
package evc_pkg;
    typedef enum logic [1:0] {
        FLD_COUNT = 2'd0,
        FLD_LIMIT = 2'd1,
        FLD_CTRL  = 2'd2,
        FLD_PEND  = 2'd3
    } evc_field_e;
endpackage

// File: rtl/evc_counter.sv
module evc_counter
    import evc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_EVT  = 16,
    parameter int SEL_W    = 4,
    parameter bit IS_TIMER = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_bus,
    input  logic               wr_hit,
    input  evc_field_e         wr_field,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [CNT_W-1:0]   lim_o,
    output logic [CNT_W-1:0]   ctrl_o,
    output logic               pend_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, lim_q;
    logic [SEL_W-1:0] sel_q;
    logic             en_q, pend_q, pend_d;
    logic             step, adv, hit_lim;
    logic             wr_cnt, wr_lim, wr_ctl, wr_clr;

    assign wr_cnt = wr_hit && (wr_field == FLD_COUNT);
    assign wr_lim = wr_hit && (wr_field == FLD_LIMIT);
    assign wr_ctl = wr_hit && (wr_field == FLD_CTRL);
    assign wr_clr = wr_hit && (wr_field == FLD_PEND) && wr_data[0];

    // next-state process
    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        if (IS_TIMER) begin
            step = en_q;
            adv  = step;
        end else begin
            step = en_q && (int'(sel_q) < NUM_EVT) && evt_bus[sel_q];
            adv  = step && (cnt_q != '1);
        end
        hit_lim = adv && (cnt_inc == lim_q);
        cnt_d = cnt_q;
        if (adv) cnt_d = (IS_TIMER && hit_lim) ? '0 : cnt_inc;
        if (wr_cnt) cnt_d = wr_data;
        pend_d = pend_q;
        if (wr_clr)  pend_d = 1'b0;
        if (hit_lim) pend_d = 1'b1;
    end

    // register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lim_q  <= '1;
            en_q   <= 1'b0;
            sel_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
            if (wr_lim) lim_q <= wr_data;
            if (wr_ctl) begin
                en_q  <= wr_data[0];
                sel_q <= wr_data[SEL_W:1];
            end
        end
    end

    always_comb begin
        ctrl_o          = '0;
        ctrl_o[0]       = en_q;
        ctrl_o[SEL_W:1] = sel_q;
    end
    assign cnt_o  = cnt_q;
    assign lim_o  = lim_q;
    assign pend_o = pend_q;

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(wr_data)));
    p_stat_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_TIMER && cnt_q == '1 && !wr_cnt) |=> (cnt_q == '1));
    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !wr_cnt) |=> $stable(cnt_q));
    p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !wr_clr) |=> pend_q);
    p_timer_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_TIMER && en_q && !wr_cnt && cnt_inc == lim_q) |=> (cnt_q == '0 && pend_q));
endmodule

// File: rtl/evc_prio.sv
module evc_prio #(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     pend,
    output logic             valid,
    output logic [IDX_W-1:0] id
);
    always_comb begin
        valid = 1'b0;
        id    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                valid = 1'b1;
                id    = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/evc_array.sv
module evc_array
    import evc_pkg::*;
#(
    parameter int NUM_CNT   = 64,
    parameter int NUM_TIMER = 32,
    parameter int CNT_W     = 16,
    parameter int NUM_EVT   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_EVT-1:0]         evt_bus,
    input  logic                       sr_wr_en,
    input  logic [$clog2(NUM_CNT)-1:0] sr_idx,
    input  logic [1:0]                 sr_field,
    input  logic [CNT_W-1:0]           sr_wdata,
    output logic [CNT_W-1:0]           sr_rdata,
    output logic                       irq_valid,
    output logic [$clog2(NUM_CNT)-1:0] irq_id
);
    localparam int IDX_W = $clog2(NUM_CNT);
    localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam logic [NUM_CNT-1:0] ONE = NUM_CNT'(1);

    evc_field_e       fld;
    logic [CNT_W-1:0] cnt_a  [NUM_CNT];
    logic [CNT_W-1:0] lim_a  [NUM_CNT];
    logic [CNT_W-1:0] ctrl_a [NUM_CNT];
    logic [NUM_CNT-1:0] pend_vec;

    assign fld = evc_field_e'(sr_field);

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        evc_counter #(
            .CNT_W   (CNT_W),
            .NUM_EVT (NUM_EVT),
            .SEL_W   (SEL_W),
            .IS_TIMER(g < NUM_TIMER)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_bus (evt_bus),
            .wr_hit  (sr_wr_en && (sr_idx == IDX_W'(g))),
            .wr_field(fld),
            .wr_data (sr_wdata),
            .cnt_o   (cnt_a[g]),
            .lim_o   (lim_a[g]),
            .ctrl_o  (ctrl_a[g]),
            .pend_o  (pend_vec[g])
        );
    end

    always_comb begin
        unique case (fld)
            FLD_COUNT: sr_rdata = cnt_a[sr_idx];
            FLD_LIMIT: sr_rdata = lim_a[sr_idx];
            FLD_CTRL:  sr_rdata = ctrl_a[sr_idx];
            FLD_PEND:  sr_rdata = CNT_W'(pend_vec[sr_idx]);
            default:   sr_rdata = '0;
        endcase
    end

    evc_prio #(.N(NUM_CNT), .IDX_W(IDX_W)) u_prio (
        .pend (pend_vec),
        .valid(irq_valid),
        .id   (irq_id)
    );

    p_irq_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> pend_vec[irq_id]);
    p_irq_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ((pend_vec & ((ONE << irq_id) - ONE)) == '0));
    p_irq_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec != '0) |-> irq_valid);
endmodule

// File: tb/tb_evc_array.sv
module tb_evc_array;
    localparam int NC = 8, NT = 4, CW = 8, NE = 4, IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_bus = '0;
    logic          sr_wr_en = 1'b0;
    logic [IW-1:0] sr_idx = '0;
    logic [1:0]    sr_field = '0;
    logic [CW-1:0] sr_wdata = '0;
    logic [CW-1:0] sr_rdata;
    logic          irq_valid;
    logic [IW-1:0] irq_id;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evc_array #(.NUM_CNT(NC), .NUM_TIMER(NT), .CNT_W(CW), .NUM_EVT(NE)) dut (
        .clk(clk), .rst_n(rst_n), .evt_bus(evt_bus), .sr_wr_en(sr_wr_en),
        .sr_idx(sr_idx), .sr_field(sr_field), .sr_wdata(sr_wdata),
        .sr_rdata(sr_rdata), .irq_valid(irq_valid), .irq_id(irq_id)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input int idx, input int fld, input int data);
        sr_idx   = IW'(idx);
        sr_field = 2'(fld);
        sr_wdata = CW'(data);
        sr_wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sr_wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, input int fld, output int val);
        sr_idx   = IW'(idx);
        sr_field = 2'(fld);
        #1;
        val = int'(sr_rdata);
    endtask

    task automatic t_reset();
        int v;
        rd(0, 0, v); check("R1 count after reset", v, 0);
        rd(5, 1, v); check("R1 limit after reset", v, 255);
        rd(2, 2, v); check("R1 control after reset", v, 0);
        rd(7, 3, v); check("R1 pending after reset", v, 0);
        check("R1 irq_valid after reset", int'(irq_valid), 0);
        wr(6, 2, 8'hF6);
        rd(6, 2, v); check("R2 control readback masks upper bits", v, 6);
    endtask

    task automatic t_timer();
        int v;
        wr(1, 1, 3);
        wr(1, 2, 1);
        cycles(2);
        rd(1, 0, v); check("R3 timer counts each cycle", v, 2);
        rd(1, 3, v); check("R4 no pending before limit", v, 0);
        cycles(1);
        rd(1, 0, v); check("R4 timer reloads to zero", v, 0);
        rd(1, 3, v); check("R4 timer pending at limit", v, 1);
        check("R9 irq_valid with timer pending", int'(irq_valid), 1);
        check("R9 irq_id names timer", int'(irq_id), 1);
        wr(1, 2, 0);
        rd(1, 0, v); check("R3 last step before disable", v, 1);
        cycles(2);
        rd(1, 0, v); check("R3 disabled timer holds", v, 1);
    endtask

    task automatic t_priority();
        int v;
        wr(3, 1, 2);
        wr(3, 2, 1);
        cycles(2);
        rd(3, 3, v); check("R4 second timer pending", v, 1);
        check("R9 lowest pending wins", int'(irq_id), 1);
        wr(1, 3, 0);
        check("R8 write of zero keeps pending", int'(irq_id), 1);
        wr(1, 3, 1);
        rd(1, 3, v); check("R8 write of one clears pending", v, 0);
        check("R9 next pending presented", int'(irq_id), 3);
        wr(3, 2, 0);
        wr(3, 3, 1);
        check("R9 irq_valid drops when none pending", int'(irq_valid), 0);
    endtask

    task automatic t_stats_select();
        int v;
        wr(5, 1, 3);
        wr(5, 2, 3);
        evt_bus = 4'b1101;
        cycles(3);
        rd(5, 0, v); check("R5 unselected events ignored", v, 0);
        rd(6, 0, v); check("R5 disabled counter ignores events", v, 0);
        evt_bus = 4'b0010;
        cycles(2);
        rd(5, 0, v); check("R5 selected event counts", v, 2);
        rd(5, 3, v); check("R7 no pending below limit", v, 0);
        cycles(1);
        rd(5, 3, v); check("R7 stats pending at limit", v, 1);
        check("R9 irq_id names stats counter", int'(irq_id), 5);
        cycles(1);
        rd(5, 0, v); check("R7 keeps counting past limit", v, 4);
        evt_bus = '0;
        wr(5, 3, 1);
    endtask

    task automatic t_saturate();
        int v;
        wr(4, 0, 253);
        wr(4, 2, 5);
        evt_bus = 4'b0100;
        cycles(5);
        rd(4, 0, v); check("R6 saturates at all-ones", v, 255);
        rd(4, 3, v); check("R7 pending on reaching all-ones limit", v, 1);
        wr(4, 3, 1);
        cycles(2);
        rd(4, 0, v); check("R6 stays saturated", v, 255);
        rd(4, 3, v); check("R6 no pending while held", v, 0);
    endtask

    task automatic t_write_wins();
        int v;
        wr(4, 0, 100);
        rd(4, 0, v); check("R10 write beats increment", v, 100);
        cycles(1);
        rd(4, 0, v); check("R5 counts after write", v, 101);
        wr(4, 0, 20);
        rd(4, 0, v); check("R10 write beats increment again", v, 20);
        evt_bus = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timer();
        t_priority();
        t_stats_select();
        t_saturate();
        t_write_wins();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule